// File: doc/BRIEF.md
# Accumulator MAC micro-core cell

A small single-issue processor tile built for multiply-accumulate kernels. It holds a 64-bit program counter, a 64-bit accumulator, eight 64-bit scalar registers, a weight pointer and a stream pointer. It also holds four 256-entry local memories: program words, scalar data, resident weights and streamed operands. Each memory has one synchronous write port and combinational reads. The scalar data memory has a second read port so that a load and a debug read can happen in the same cycle.

A host fills the memories through one write port per memory while the tile is halted, then pulses start. The tile runs one instruction per cycle until it reaches a halt. The host watches the run state, the architectural registers and two 64-bit counters. Debug ports read any scalar register and any data word combinationally. Every memory index is taken from the low 8 bits of the address or PC that selects it.

Top module: `mac_tile`

## Requirements
- R1: After rst_n is low, halted=1, busy=0, and pc, acc, both pointers, cycle_count, retire_count and all scalar registers are zero.
- R2: A start pulse while halted makes busy=1 and halted=0 on the next cycle, with pc=0. A start pulse while busy is ignored.
- R3: Host writes to any memory take effect only while halted. A write presented while busy leaves the memory unchanged.
- R4: Every busy cycle adds one to cycle_count and one to retire_count. While halted and not started, both counters hold.
- R5: The instruction word has opcode [31:28], rd [27:24], ra [23:20], rb [19:16] and imm [15:0]. A register field uses its low 3 bits. Opcode 10 (halt) and the unused opcodes 11 to 15 set halted, clear busy, freeze pc and still retire.
- R6: Opcode 0 adds the low 64 bits of the signed product ra*rb to acc. Opcode 2 clears acc. Opcode 3 copies acc into rd.
- R7: Opcode 1 adds the signed product of the 32-bit words weight[wptr] and stream[sptr] to acc, then increments both 16-bit pointers.
- R8: Opcode 4 writes the sign-extended imm to rd. Opcode 5 loads data[ra+sext(imm)] into rd. Opcode 6 stores rb to data[ra+sext(imm)]. All memory indexes, including host and debug addresses, use only the low 8 bits.
- R9: Opcode 7 loads imm into the weight pointer. Opcode 8 loads imm into the stream pointer.
- R10: Opcode 9 is taken when ra is negative, and then the next pc is pc+sext(imm), counted from the branch's own pc. When it is not taken, the next pc is pc+1. The instruction fetch uses pc[7:0].
- R11: peek_reg_data shows register peek_reg_sel and peek_mem_data shows data[peek_mem_addr] combinationally, also during execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Run request, acted on while halted |
| prog_we | input | 1 | Program memory write enable |
| prog_addr | input | 16 | Program memory write address |
| prog_wdata | input | 32 | Program word |
| dmem_we | input | 1 | Data memory write enable |
| dmem_addr | input | 16 | Data memory write address |
| dmem_wdata | input | 64 | Data word |
| wgt_we | input | 1 | Weight memory write enable |
| wgt_addr | input | 16 | Weight memory write address |
| wgt_wdata | input | 32 | Weight element |
| strm_we | input | 1 | Stream memory write enable |
| strm_addr | input | 16 | Stream memory write address |
| strm_wdata | input | 32 | Stream element |
| peek_reg_sel | input | 3 | Debug register select |
| peek_mem_addr | input | 16 | Debug data memory address |
| halted | output | 1 | Tile is stopped |
| busy | output | 1 | Tile is executing |
| pc | output | 64 | Program counter |
| acc | output | 64 | Accumulator |
| wgt_ptr | output | 16 | Weight pointer |
| strm_ptr | output | 16 | Stream pointer |
| cycle_count | output | 64 | Busy cycles since reset |
| retire_count | output | 64 | Instructions retired since reset |
| peek_reg_data | output | 64 | Selected register value |
| peek_mem_data | output | 64 | Selected data word |

## Verification
A bad next-pc choice shows up at the end of the run as a wrong final pc and wrong counts, because the retired count and the cycle count then no longer match the path through the program. A wrong accumulator, pointer or register update stays in architectural state, so it can be read at the ports once the tile halts. A write that gets through while the tile is busy is caught by reading the data memory back through the debug port, and by a program word that is not overwritten. The assertions catch counter, start, halt, pointer and branch errors within one cycle of the event.

// File: rtl/mac_tile_pkg.sv
package mac_tile_pkg;
  localparam int XW   = 64;  // scalar / accumulator width
  localparam int EW   = 32;  // weight and stream element width
  localparam int IWW  = 32;  // instruction width
  localparam int HAW  = 16;  // host / pointer address width
  localparam int MDEP = 256; // local memory depth
  localparam int MIW  = $clog2(MDEP);
  localparam int NREG = 8;
  localparam int RIW  = $clog2(NREG);

  localparam logic [3:0] OP_MAC    = 4'd0;
  localparam logic [3:0] OP_KMAC   = 4'd1;
  localparam logic [3:0] OP_CLRACC = 4'd2;
  localparam logic [3:0] OP_MOVACC = 4'd3;
  localparam logic [3:0] OP_LI     = 4'd4;
  localparam logic [3:0] OP_LD     = 4'd5;
  localparam logic [3:0] OP_ST     = 4'd6;
  localparam logic [3:0] OP_SETW   = 4'd7;
  localparam logic [3:0] OP_SETS   = 4'd8;
  localparam logic [3:0] OP_BLZ    = 4'd9;
  localparam logic [3:0] OP_HALT   = 4'd10;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  rd;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [15:0] imm;
  } insn_t;

  function automatic logic [XW-1:0] sext_imm(input logic [15:0] v);
    return {{(XW-16){v[15]}}, v};
  endfunction

  function automatic logic [XW-1:0] scalar_mac(input logic [XW-1:0] a,
                                               input logic [XW-1:0] x,
                                               input logic [XW-1:0] y);
    logic signed [XW-1:0] p;
    p = $signed(x) * $signed(y);
    return a + p;
  endfunction

  function automatic logic [XW-1:0] elem_mac(input logic [XW-1:0] a,
                                             input logic [EW-1:0] w,
                                             input logic [EW-1:0] s);
    logic signed [XW-1:0] wx, sx, p;
    wx = $signed({{(XW-EW){w[EW-1]}}, w});
    sx = $signed({{(XW-EW){s[EW-1]}}, s});
    p  = wx * sx;
    return a + p;
  endfunction

  function automatic logic stops_run(input logic [3:0] op);
    return op >= OP_HALT;
  endfunction
endpackage

// File: rtl/tile_mem.sv
module tile_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 256,
  parameter int NRD   = 1,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IW-1:0]     waddr,
  input  logic [W-1:0]      wdata,
  input  logic [NRD*IW-1:0] raddr,
  output logic [NRD*W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g*W +: W] = mem[raddr[g*IW +: IW]];
  end
endmodule

// File: rtl/tile_regs.sv
module tile_regs #(
  parameter int N   = 8,
  parameter int W   = 64,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [IW-1:0] ra,
  input  logic [IW-1:0] rb,
  input  logic [IW-1:0] rc,
  output logic [W-1:0]  da,
  output logic [W-1:0]  db,
  output logic [W-1:0]  dc
);
  logic [W-1:0] r [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) r[i] <= '0;
    end else if (we) begin
      r[wa] <= wd;
    end
  end

  assign da = r[ra];
  assign db = r[rb];
  assign dc = r[rc];
endmodule

// File: rtl/mac_tile.sv
module mac_tile
  import mac_tile_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          prog_we,
  input  logic [15:0]   prog_addr,
  input  logic [31:0]   prog_wdata,
  input  logic          dmem_we,
  input  logic [15:0]   dmem_addr,
  input  logic [63:0]   dmem_wdata,
  input  logic          wgt_we,
  input  logic [15:0]   wgt_addr,
  input  logic [31:0]   wgt_wdata,
  input  logic          strm_we,
  input  logic [15:0]   strm_addr,
  input  logic [31:0]   strm_wdata,
  input  logic [2:0]    peek_reg_sel,
  input  logic [15:0]   peek_mem_addr,
  output logic          halted,
  output logic          busy,
  output logic [63:0]   pc,
  output logic [63:0]   acc,
  output logic [15:0]   wgt_ptr,
  output logic [15:0]   strm_ptr,
  output logic [63:0]   cycle_count,
  output logic [63:0]   retire_count,
  output logic [63:0]   peek_reg_data,
  output logic [63:0]   peek_mem_data
);
  // architectural state
  logic          halted_q;
  logic [XW-1:0] pc_q, acc_q, cyc_q, ret_q;
  logic [HAW-1:0] wp_q, sp_q;

  // decode
  logic [IWW-1:0] fetch_word;
  insn_t          ins;
  logic [XW-1:0]  imm_x, ra_val, rb_val, eff_addr, ld_val;
  logic [EW-1:0]  w_elem, s_elem;
  logic [RIW-1:0] rd_i, ra_i, rb_i;

  // named events for the checker
  logic          exec, start_evt, halt_evt, kmac_evt, br_taken;
  logic [XW-1:0] br_off;

  assign ins   = insn_t'(fetch_word);
  assign rd_i  = ins.rd[RIW-1:0];
  assign ra_i  = ins.ra[RIW-1:0];
  assign rb_i  = ins.rb[RIW-1:0];
  assign imm_x = sext_imm(ins.imm);
  assign eff_addr = ra_val + imm_x;

  assign exec      = ~halted_q;
  assign start_evt = halted_q & start;
  assign halt_evt  = exec & stops_run(ins.op);
  assign kmac_evt  = exec & (ins.op == OP_KMAC);
  assign br_off    = imm_x;
  assign br_taken  = exec & (ins.op == OP_BLZ) & ra_val[XW-1];

  // register file write
  logic          rf_we;
  logic [XW-1:0] rf_wd;
  always_comb begin
    rf_we = 1'b0;
    rf_wd = '0;
    if (exec) begin
      unique case (ins.op)
        OP_LI:     begin rf_we = 1'b1; rf_wd = imm_x;  end
        OP_LD:     begin rf_we = 1'b1; rf_wd = ld_val; end
        OP_MOVACC: begin rf_we = 1'b1; rf_wd = acc_q;  end
        default:   ;
      endcase
    end
  end

  tile_regs #(.N(NREG), .W(XW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(rf_we), .wa(rd_i), .wd(rf_wd),
    .ra(ra_i), .rb(rb_i), .rc(peek_reg_sel),
    .da(ra_val), .db(rb_val), .dc(peek_reg_data)
  );

  // memories: host port while halted, core store port while running
  logic           d_we;
  logic [MIW-1:0] d_wa;
  logic [XW-1:0]  d_wd;
  assign d_we = halted_q ? dmem_we : (exec & (ins.op == OP_ST));
  assign d_wa = halted_q ? dmem_addr[MIW-1:0] : eff_addr[MIW-1:0];
  assign d_wd = halted_q ? dmem_wdata : rb_val;

  tile_mem #(.W(IWW), .DEPTH(MDEP), .NRD(1)) u_prog (
    .clk(clk), .we(prog_we & halted_q), .waddr(prog_addr[MIW-1:0]),
    .wdata(prog_wdata), .raddr(pc_q[MIW-1:0]), .rdata(fetch_word)
  );

  logic [2*XW-1:0] d_rd;
  tile_mem #(.W(XW), .DEPTH(MDEP), .NRD(2)) u_data (
    .clk(clk), .we(d_we), .waddr(d_wa), .wdata(d_wd),
    .raddr({peek_mem_addr[MIW-1:0], eff_addr[MIW-1:0]}), .rdata(d_rd)
  );
  assign ld_val        = d_rd[XW-1:0];
  assign peek_mem_data = d_rd[2*XW-1:XW];

  tile_mem #(.W(EW), .DEPTH(MDEP), .NRD(1)) u_wgt (
    .clk(clk), .we(wgt_we & halted_q), .waddr(wgt_addr[MIW-1:0]),
    .wdata(wgt_wdata), .raddr(wp_q[MIW-1:0]), .rdata(w_elem)
  );

  tile_mem #(.W(EW), .DEPTH(MDEP), .NRD(1)) u_strm (
    .clk(clk), .we(strm_we & halted_q), .waddr(strm_addr[MIW-1:0]),
    .wdata(strm_wdata), .raddr(sp_q[MIW-1:0]), .rdata(s_elem)
  );

  // sequencing and execute
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b1;
      pc_q     <= '0;
      acc_q    <= '0;
      cyc_q    <= '0;
      ret_q    <= '0;
      wp_q     <= '0;
      sp_q     <= '0;
    end else if (start_evt) begin
      halted_q <= 1'b0;
      pc_q     <= '0;
    end else if (exec) begin
      cyc_q <= cyc_q + 1'b1;
      ret_q <= ret_q + 1'b1;
      if (halt_evt)      halted_q <= 1'b1;
      else if (br_taken) pc_q <= pc_q + br_off;
      else               pc_q <= pc_q + 1'b1;
      unique case (ins.op)
        OP_MAC:    acc_q <= scalar_mac(acc_q, ra_val, rb_val);
        OP_KMAC: begin
          acc_q <= elem_mac(acc_q, w_elem, s_elem);
          wp_q  <= wp_q + 1'b1;
          sp_q  <= sp_q + 1'b1;
        end
        OP_CLRACC: acc_q <= '0;
        OP_SETW:   wp_q  <= ins.imm;
        OP_SETS:   sp_q  <= ins.imm;
        default:   ;
      endcase
    end
  end

  assign halted       = halted_q;
  assign busy         = exec;
  assign pc           = pc_q;
  assign acc          = acc_q;
  assign wgt_ptr      = wp_q;
  assign strm_ptr     = sp_q;
  assign cycle_count  = cyc_q;
  assign retire_count = ret_q;
endmodule

// File: rtl/mac_tile_chk.sv
module mac_tile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        halted,
  input logic        busy,
  input logic [63:0] pc,
  input logic [63:0] cycle_count,
  input logic [63:0] retire_count,
  input logic [15:0] wgt_ptr,
  input logic [15:0] strm_ptr,
  input logic        halt_evt,
  input logic        kmac_evt,
  input logic        br_taken,
  input logic [63:0] br_off
);
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && start) |=> (busy && !halted && pc == 64'd0));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cycle_count == $past(cycle_count) + 64'd1 &&
              retire_count == $past(retire_count) + 64'd1));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> ($stable(cycle_count) && $stable(retire_count) && $stable(pc)));

  assert_halt_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> (halted && !busy && pc == $past(pc)));

  assert_kmac_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kmac_evt |=> (wgt_ptr == $past(wgt_ptr) + 16'd1 &&
                  strm_ptr == $past(strm_ptr) + 16'd1));

  assert_branch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (pc == $past(pc) + $past(br_off)));
endmodule

bind mac_tile mac_tile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .halted(halted), .busy(busy),
  .pc(pc), .cycle_count(cycle_count), .retire_count(retire_count),
  .wgt_ptr(wgt_ptr), .strm_ptr(strm_ptr), .halt_evt(halt_evt),
  .kmac_evt(kmac_evt), .br_taken(br_taken), .br_off(br_off)
);

// File: tb/test_mac_tile.sv
`timescale 1ns/1ps
module test_mac_tile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        prog_we = 1'b0, dmem_we = 1'b0, wgt_we = 1'b0, strm_we = 1'b0;
  logic [15:0] prog_addr = '0, dmem_addr = '0, wgt_addr = '0, strm_addr = '0;
  logic [31:0] prog_wdata = '0, wgt_wdata = '0, strm_wdata = '0;
  logic [63:0] dmem_wdata = '0;
  logic [2:0]  peek_reg_sel = '0;
  logic [15:0] peek_mem_addr = '0;
  logic        halted, busy;
  logic [63:0] pc, acc, cycle_count, retire_count, peek_reg_data, peek_mem_data;
  logic [15:0] wgt_ptr, strm_ptr;

  always #4 clk = ~clk;

  mac_tile i_mac_tile (
    .clk(clk), .rst_n(rst_n), .start(start),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_wdata(prog_wdata),
    .dmem_we(dmem_we), .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .wgt_we(wgt_we), .wgt_addr(wgt_addr), .wgt_wdata(wgt_wdata),
    .strm_we(strm_we), .strm_addr(strm_addr), .strm_wdata(strm_wdata),
    .peek_reg_sel(peek_reg_sel), .peek_mem_addr(peek_mem_addr),
    .halted(halted), .busy(busy), .pc(pc), .acc(acc),
    .wgt_ptr(wgt_ptr), .strm_ptr(strm_ptr),
    .cycle_count(cycle_count), .retire_count(retire_count),
    .peek_reg_data(peek_reg_data), .peek_mem_data(peek_mem_data)
  );

  // selectors for the scoreboard
  localparam int S_ACC = 0, S_PC = 1, S_HALT = 2, S_BUSY = 3, S_WP = 4,
                 S_SP = 5, S_CYC = 6, S_RET = 7, S_REG = 8, S_MEM = 9;

  typedef struct {
    int          sel;
    int          idx;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_bad = 0;
  bit    finished = 0;
  event  flush_ev, mon_done;

  function automatic logic [31:0] enc(input int op, input int rd, input int ra,
                                      input int rb, input int imm);
    return {op[3:0], rd[3:0], ra[3:0], rb[3:0], imm[15:0]};
  endfunction

  task automatic expect_val(input int sel, input int idx, input logic [63:0] exp,
                            input string req);
    item_t it;
    it.sel = sel; it.idx = idx; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic flush();
    -> flush_ev;
    @(mon_done);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(flush_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [63:0] got;
        it = q.pop_front();
        if (it.sel == S_REG) peek_reg_sel  = it.idx[2:0];
        if (it.sel == S_MEM) peek_mem_addr = it.idx[15:0];
        #1;
        case (it.sel)
          S_ACC:   got = acc;
          S_PC:    got = pc;
          S_HALT:  got = {63'd0, halted};
          S_BUSY:  got = {63'd0, busy};
          S_WP:    got = {48'd0, wgt_ptr};
          S_SP:    got = {48'd0, strm_ptr};
          S_CYC:   got = cycle_count;
          S_RET:   got = retire_count;
          S_REG:   got = peek_reg_data;
          default: got = peek_mem_data;
        endcase
        n_chk++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s sel=%0d idx=%0h actual=%h expected=%h",
                   it.req, it.sel, it.idx, got, it.exp);
        end
      end
      -> mon_done;
    end
  end

  task automatic host_write(input int which, input int a, input logic [63:0] d);
    @(negedge clk);
    case (which)
      0: begin prog_we = 1; prog_addr = a[15:0]; prog_wdata = d[31:0]; end
      1: begin dmem_we = 1; dmem_addr = a[15:0]; dmem_wdata = d; end
      2: begin wgt_we = 1; wgt_addr = a[15:0]; wgt_wdata = d[31:0]; end
      default: begin strm_we = 1; strm_addr = a[15:0]; strm_wdata = d[31:0]; end
    endcase
    @(negedge clk);
    prog_we = 0; dmem_we = 0; wgt_we = 0; strm_we = 0;
  endtask

  // run from pc 0; optionally meddle with writes and start while busy
  task automatic run(input bit meddle);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    if (meddle) begin
      repeat (3) @(negedge clk);
      start = 1; dmem_we = 1; dmem_addr = 16'd20; dmem_wdata = 64'hDEAD;
      prog_we = 1; prog_addr = 16'd7; prog_wdata = enc(4, 6, 0, 0, 1);
      @(negedge clk);
      start = 0; dmem_we = 0; prog_we = 0;
    end
    for (int i = 0; i < 1000 && !halted; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    expect_val(S_HALT, 0, 1, "R1 halted");
    expect_val(S_BUSY, 0, 0, "R1 busy");
    expect_val(S_PC, 0, 0, "R1 pc");
    expect_val(S_ACC, 0, 0, "R1 acc");
    expect_val(S_WP, 0, 0, "R1 wptr");
    expect_val(S_SP, 0, 0, "R1 sptr");
    expect_val(S_CYC, 0, 0, "R1 cycles");
    expect_val(S_RET, 0, 0, "R1 retired");
    expect_val(S_REG, 5, 0, "R1 reg5");
    flush();

    // host loads while halted (R3), low-8 addressing (R8)
    host_write(1, 16'h0305, 64'h8000_0000_0000_1234);
    host_write(1, 7, 0);
    host_write(1, 20, 0);
    host_write(2, 2, 32'hFFFF_FFFB);
    host_write(2, 16'h0A03, 32'h7FFF_FFFF);
    host_write(3, 3, 32'd1000);
    host_write(3, 4, 32'd2);
    expect_val(S_MEM, 16'h0005, 64'h8000_0000_0000_1234, "R3 R8 host write low index");
    expect_val(S_MEM, 16'hFF05, 64'h8000_0000_0000_1234, "R11 R8 peek alias");
    flush();

    // program A: scalar mac, load/store, pointer kmac
    host_write(0, 0,  enc(4, 1, 0, 0, -3));      // li r1,-3
    host_write(0, 1,  enc(4, 2, 0, 0, 7));       // li r2,7
    host_write(0, 2,  enc(0, 0, 1, 2, 0));       // mac r1,r2
    host_write(0, 3,  enc(5, 3, 0, 0, 5));       // ld r3,[r0+5]
    host_write(0, 4,  enc(6, 0, 1, 2, 10));      // st r2,[r1+10] -> 7
    host_write(0, 5,  enc(3, 12, 0, 0, 0));      // movacc r4 (field 12 -> r4)
    host_write(0, 6,  enc(7, 0, 0, 0, 2));       // setwptr 2
    host_write(0, 7,  enc(8, 0, 0, 0, 16'h0103));// setsptr 0x103
    host_write(0, 8,  enc(1, 0, 0, 0, 0));       // kmac
    host_write(0, 9,  enc(1, 0, 0, 0, 0));       // kmac
    host_write(0, 10, enc(10, 0, 0, 0, 0));      // halt
    run(0);
    expect_val(S_HALT, 0, 1, "R5 halted after halt");
    expect_val(S_PC, 0, 10, "R5 pc frozen at halt");
    expect_val(S_REG, 1, -64'sd3, "R8 li sign-extend");
    expect_val(S_REG, 4, -64'sd21, "R6 mac then movacc");
    expect_val(S_REG, 3, 64'h8000_0000_0000_1234, "R8 ld");
    expect_val(S_MEM, 7, 64'd7, "R8 st effective address");
    expect_val(S_ACC, 0, -64'sd21 + (-64'sd5 * 64'sd1000) + (64'sd2147483647 * 64'sd2),
               "R7 kmac signed elements");
    expect_val(S_WP, 0, 16'd4, "R7 R9 wptr");
    expect_val(S_SP, 0, 16'h0105, "R7 R9 sptr");
    expect_val(S_CYC, 0, 11, "R4 cycles A");
    expect_val(S_RET, 0, 11, "R4 retired A");
    flush();

    // program B: countdown loop with blz, meddling while busy
    host_write(0, 0, enc(4, 1, 0, 0, -4));       // li r1,-4
    host_write(0, 1, enc(4, 2, 0, 0, 1));        // li r2,1
    host_write(0, 2, enc(2, 0, 0, 0, 0));        // clracc
    host_write(0, 3, enc(0, 0, 1, 2, 0));        // mac r1,r2 -> acc=-4
    host_write(0, 4, enc(0, 0, 2, 2, 0));        // mac r2,r2 -> acc+1
    host_write(0, 5, enc(3, 3, 0, 0, 0));        // movacc r3
    host_write(0, 6, enc(9, 0, 3, 0, -2));       // blz r3,-2 -> pc 4
    host_write(0, 7, enc(10, 0, 0, 0, 0));       // halt
    run(1);
    expect_val(S_PC, 0, 7, "R10 branch offset from own pc");
    expect_val(S_ACC, 0, 0, "R6 R10 loop acc");
    expect_val(S_REG, 6, 0, "R3 program write while busy ignored");
    expect_val(S_MEM, 20, 0, "R3 data write while busy ignored");
    expect_val(S_CYC, 0, 28, "R2 R4 start while busy ignored");
    expect_val(S_RET, 0, 28, "R4 retired B");
    flush();

    // program C: negative branch wraps pc, fetch uses pc[7:0], unused opcode halts
    host_write(0, 0, enc(4, 1, 0, 0, -1));       // li r1,-1
    host_write(0, 1, enc(9, 0, 1, 0, -16));      // blz r1,-16
    host_write(0, 16'h00F1, enc(13, 0, 0, 0, 0));// unused opcode
    run(0);
    expect_val(S_PC, 0, 64'hFFFF_FFFF_FFFF_FFF1, "R10 R5 wrapped pc and unused opcode");
    expect_val(S_HALT, 0, 1, "R5 unused opcode halts");
    expect_val(S_BUSY, 0, 0, "R5 busy clear");
    expect_val(S_RET, 0, 31, "R4 R5 retired C");
    flush();

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule